// File: doc/BRIEF.md
# Binary64 to Signed 32-bit Integer Truncating Converter

This unit takes one IEEE 754 binary64 operand and produces the 32-bit two's-complement integer nearest to it in the direction of zero. No rounding-mode input exists. The conversion always discards the fractional part. The converter classifies the operand into five classes: zero, subnormal, normal, infinity or NaN. It returns a single indefinite code, 0x80000000, for every operand that a signed 32-bit integer cannot represent. It also reports two flags. The invalid flag marks an unrepresentable or NaN operand. The inexact flag marks a conversion in which nonzero fraction bits were dropped.

An execution pipeline uses the unit as one conversion lane. It drives an operand with a valid strobe. In the default registered build, the result, the two flags and an output valid appear on the following clock. A parameter selects a purely combinational build instead. Between strobes, the registered outputs keep the last converted value.

Top module: `fp64_to_i32_trunc`

## Requirements
- R1: An in-range normal operand returns its value truncated toward zero, for both signs (for example 2.5 gives 2 and -2.5 gives -2).
- R2: The operand is decoded as follows: sign in bit 63, biased exponent in bits 62:52 with bias 1023, and fraction in bits 51:0. Normal numbers carry an implied leading one.
- R3: An operand whose truncated value is 2147483648 or more, or -2147483649 or less, returns 0x80000000 with invalid set.
- R4: An operand that truncates to exactly -2147483648 (for example -2147483648.5) is valid. It returns 0x80000000 with invalid clear.
- R5: A NaN operand (exponent all ones, fraction nonzero, quiet or signalling, either sign) returns 0x80000000 with invalid set.
- R6: An infinity of either sign (exponent all ones, fraction zero) returns 0x80000000 with invalid set.
- R7: Positive and negative zero return 0 with both flags clear.
- R8: A subnormal operand (exponent zero, fraction nonzero) returns 0 with inexact set and invalid clear.
- R9: A nonzero normal operand of magnitude below one returns 0 with inexact set.
- R10: Inexact is set exactly when nonzero fraction bits are discarded. An integral operand in range raises no flag.
- R11: Invalid and inexact are never both set for the same result.
- R12: With registered output, the result and flags appear one clock after the operand strobe, and out_valid is the strobe delayed by one clock. Synchronous active-low reset clears all outputs to zero. While no strobe arrives, the result and flags hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Signed integer result or 0x80000000 |
| out_invalid | output | 1 | Unrepresentable or NaN operand |
| out_inexact | output | 1 | Fraction bits were discarded |

## Verification
The assertions are checked on every cycle. They confirm that:
- the output strobe follows the input strobe by one clock;
- the outputs hold between strobes;
- an invalid result always carries the indefinite code;
- the two flags never coincide;
- NaN operands always raise invalid;
- signed zeros convert cleanly.

Only the bench's scenarios can show the arithmetic itself, which the bench compares against an independent real-valued reference model. That arithmetic covers truncation of fractions of both signs, the exact edges at plus and minus 2^31, subnormals, values below one, and a sweep of pseudo-random exponents around the 32-bit range.

// File: rtl/fp64i32_pkg.sv
// Package: shared operand class encoding for the binary64 to int32 converter.
// Assumes: nothing beyond IEEE 754 binary interchange field layout.
package fp64i32_pkg;

    typedef enum logic [2:0] {
        FPC_ZERO = 3'd0,
        FPC_SUBN = 3'd1,
        FPC_NORM = 3'd2,
        FPC_INF  = 3'd3,
        FPC_NAN  = 3'd4
    } fp_class_e;

endpackage

// File: rtl/fp_field_decode.sv
// Module: fp_field_decode
// Splits a binary floating-point operand into sign, biased exponent and
// significand (implied one restored for normals) and classifies it.
// Assumes: sign is the top bit, exponent directly below, fraction at bit 0.
module fp_field_decode
    import fp64i32_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int OP_W   = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic [OP_W-1:0]   operand,
    output logic              sign,
    output logic [EXP_W-1:0]  exp_biased,
    output logic [MANT_W-1:0] mant,
    output fp_class_e         cls
);

    logic [FRAC_W-1:0] frac;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;

    assign sign       = operand[OP_W-1];
    assign exp_biased = operand[OP_W-2:FRAC_W];
    assign frac       = operand[FRAC_W-1:0];
    assign exp_zero   = (exp_biased == '0);
    assign exp_ones   = (exp_biased == '1);
    assign frac_zero  = (frac == '0);

    // Restore the implied leading one only for normal encodings.
    assign mant = {~exp_zero, frac};

    // Sort the operand into one of five classes.
    always_comb begin
        if (exp_ones)       cls = frac_zero ? FPC_INF : FPC_NAN;
        else if (exp_zero)  cls = frac_zero ? FPC_ZERO : FPC_SUBN;
        else                cls = FPC_NORM;
    end

endmodule

// File: rtl/fp_trunc_core.sv
// Module: fp_trunc_core
// Aligns the significand of a normal operand to the integer point, keeping
// the integer part as an unsigned magnitude and reporting discarded bits.
// Assumes: FRAC_W >= INT_W - 1, so an in-range value is a right shift.
module fp_trunc_core
    import fp64i32_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 32,
    localparam int MANT_W = FRAC_W + 1,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1,
    localparam int SH_W   = $clog2(MANT_W + 1)
) (
    input  logic [EXP_W-1:0]  exp_biased,
    input  logic [MANT_W-1:0] mant,
    input  fp_class_e         cls,
    output logic [INT_W-1:0]  mag,
    output logic              too_big,
    output logic              lost
);

    logic [EXP_W-1:0]  unb_exp;
    logic [EXP_W-1:0]  sh_full;
    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] drop_mask;
    logic              below_one;
    logic              over_width;

    assign below_one  = (exp_biased < EXP_W'(BIAS));
    assign over_width = (exp_biased >= EXP_W'(BIAS + INT_W));
    assign unb_exp    = exp_biased - EXP_W'(BIAS);
    assign sh_full    = EXP_W'(FRAC_W) - unb_exp;
    assign sh         = sh_full[SH_W-1:0];
    assign shifted    = mant >> sh;
    assign drop_mask  = ~({MANT_W{1'b1}} << sh);

    // Pick magnitude, overflow and discard status by operand class.
    always_comb begin
        mag     = '0;
        too_big = 1'b0;
        lost    = 1'b0;
        unique case (cls)
            FPC_NORM: begin
                if (below_one) begin
                    lost = 1'b1;
                end else if (over_width) begin
                    too_big = 1'b1;
                end else begin
                    mag  = shifted[INT_W-1:0];
                    lost = |(mant & drop_mask);
                end
            end
            FPC_SUBN: lost = 1'b1;
            FPC_INF, FPC_NAN: too_big = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fp_range_pack.sv
// Module: fp_range_pack
// Applies the signed range limits, substitutes the indefinite code for any
// unrepresentable value, negates in-range negatives and masks inexact.
// Assumes: mag is the truncated magnitude when too_big is clear.
module fp_range_pack
    import fp64i32_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign,
    input  fp_class_e        cls,
    input  logic [INT_W-1:0] mag,
    input  logic             too_big,
    input  logic             lost,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);

    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    logic top_set;
    logic rest_set;
    logic range_bad;

    assign top_set  = mag[INT_W-1];
    assign rest_set = |mag[INT_W-2:0];

    // Positive limit is 2^(W-1)-1; negative limit is -2^(W-1).
    assign range_bad = too_big | (top_set & (~sign | rest_set));

    // Form the flags; NaN and infinity are always invalid.
    always_comb begin
        invalid = (cls == FPC_NAN) || (cls == FPC_INF) || range_bad;
        inexact = lost & ~invalid;
    end

    // Select the indefinite code, or the signed truncated value.
    always_comb begin
        if (invalid)    result = INDEF;
        else if (sign)  result = INT_W'(~mag + 1'b1);
        else            result = mag;
    end

endmodule

// File: rtl/fp64_to_i32_trunc.sv
// Module: fp64_to_i32_trunc
// Top of the truncating binary64 to int32 converter. Decodes, aligns and
// range-checks one operand; REG_OUT=1 registers the outputs one clock
// after the strobe, REG_OUT=0 passes them straight through.
// Assumes: synchronous active-low reset; operand only sampled with in_valid.
module fp64_to_i32_trunc
    import fp64i32_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter int INT_W   = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int OP_W   = 1 + EXP_W + FRAC_W,
    localparam int MANT_W = FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_operand,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_inexact
);

    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    logic              dec_sign;
    logic [EXP_W-1:0]  dec_exp;
    logic [MANT_W-1:0] dec_mant;
    fp_class_e         dec_cls;
    logic [INT_W-1:0]  core_mag;
    logic              core_big;
    logic              core_lost;
    logic [INT_W-1:0]  nxt_result;
    logic              nxt_invalid;
    logic              nxt_inexact;

    fp_field_decode #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_decode (
        .operand    (in_operand),
        .sign       (dec_sign),
        .exp_biased (dec_exp),
        .mant       (dec_mant),
        .cls        (dec_cls)
    );

    fp_trunc_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_core (
        .exp_biased (dec_exp),
        .mant       (dec_mant),
        .cls        (dec_cls),
        .mag        (core_mag),
        .too_big    (core_big),
        .lost       (core_lost)
    );

    fp_range_pack #(.INT_W(INT_W)) u_pack (
        .sign    (dec_sign),
        .cls     (dec_cls),
        .mag     (core_mag),
        .too_big (core_big),
        .lost    (core_lost),
        .result  (nxt_result),
        .invalid (nxt_invalid),
        .inexact (nxt_inexact)
    );

    generate
        if (REG_OUT) begin : g_reg
            // Capture the converted value on each strobe; hold otherwise.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid   <= 1'b0;
                    out_result  <= '0;
                    out_invalid <= 1'b0;
                    out_inexact <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        out_result  <= nxt_result;
                        out_invalid <= nxt_invalid;
                        out_inexact <= nxt_inexact;
                    end
                end
            end

            // R12: output strobe is the input strobe one clock later.
            p_strobe_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_strobe_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            // R12: outputs hold while no operand arrives.
            p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(out_result) && $stable(out_invalid)
                               && $stable(out_inexact)));
            // R3: an invalid result carries the indefinite code.
            p_indef_on_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_invalid) |-> (out_result == INDEF));
            // R11: the two flags never coincide.
            p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> !(out_invalid && out_inexact));
            // R5: NaN operands always raise invalid.
            p_nan_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_operand[OP_W-2:FRAC_W] == '1)
                 && (in_operand[FRAC_W-1:0] != '0)) |=> out_invalid);
            // R7: signed zeros convert to 0 with no flag.
            p_zero_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_operand[OP_W-2:0] == '0)) |=>
                (out_result == '0 && !out_invalid && !out_inexact));
        end else begin : g_comb
            assign out_valid   = in_valid;
            assign out_result  = nxt_result;
            assign out_invalid = nxt_invalid;
            assign out_inexact = nxt_inexact;
        end
    endgenerate

endmodule

// File: tb/fp64_to_i32_trunc_tb.sv
// Scoreboard bench: the driver pushes reference results into queues, the
// monitor pops and compares them when the converter reports a result.
module fp64_to_i32_trunc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    logic [31:0] q_res[$];
    logic        q_inv[$];
    logic        q_inx[$];
    int          q_stamp[$];
    string       q_tag[$];

    logic [31:0] last_res = '0;
    logic        last_inv = 1'b0;
    logic        last_inx = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    fp64_to_i32_trunc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    // Reference model built on real arithmetic, independent of the RTL.
    function automatic void ref_conv(input logic [63:0] x, output logic [31:0] r,
                                     output logic inv, output logic inx);
        real v;
        int  t;
        if (x[62:52] == 11'h7FF) begin
            r = 32'h8000_0000; inv = 1'b1; inx = 1'b0;
        end else begin
            v = $bitstoreal(x);
            if (v >= 2147483648.0 || v <= -2147483649.0) begin
                r = 32'h8000_0000; inv = 1'b1; inx = 1'b0;
            end else begin
                t = $rtoi(v);
                r = t; inv = 1'b0; inx = ($itor(t) != v);
            end
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v,
                         input string what);
        compared++;
        if (act !== exp_v) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp_v);
        end
    endtask

    task automatic send(input logic [63:0] x, input string tag);
        logic [31:0] r;
        logic        inv;
        logic        inx;
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = x;
        ref_conv(x, r, inv, inx);
        q_res.push_back(r);
        q_inv.push_back(inv);
        q_inx.push_back(inx);
        q_stamp.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_operand = {rng[31:0], rng[63:32]};
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 7);
        v = v ^ (v << 17);
        return v;
    endfunction

    // Monitor: compares strobe timing, result values and held outputs.
    initial begin
        logic exp_valid;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                exp_valid = (q_stamp.size() > 0) && (q_stamp[0] + 1 == cyc);
                check("R12", {63'd0, out_valid}, {63'd0, exp_valid}, "out_valid timing");
                if (out_valid && exp_valid) begin
                    check(q_tag[0], {32'd0, out_result}, {32'd0, q_res[0]}, "result");
                    check(q_tag[0], {63'd0, out_invalid}, {63'd0, q_inv[0]}, "invalid");
                    check(q_tag[0], {63'd0, out_inexact}, {63'd0, q_inx[0]}, "inexact");
                    last_res = q_res[0];
                    last_inv = q_inv[0];
                    last_inx = q_inx[0];
                    void'(q_res.pop_front());
                    void'(q_inv.pop_front());
                    void'(q_inx.pop_front());
                    void'(q_stamp.pop_front());
                    void'(q_tag.pop_front());
                end else if (!out_valid) begin
                    check("R12", {31'd0, out_result, out_invalid}, {31'd0, last_res, last_inv},
                          "held result");
                    check("R12", {63'd0, out_inexact}, {63'd0, last_inx}, "held inexact");
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog (R12): actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R12", {29'd0, out_valid, out_invalid, out_inexact}, 64'd0, "reset flags");
        check("R12", {32'd0, out_result}, 64'd0, "reset result");
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        send(64'h3FF0_0000_0000_0000, "R1");   // 1.0
        send(64'hBFF0_0000_0000_0000, "R1");   // -1.0
        send(64'h4004_0000_0000_0000, "R1");   // 2.5
        send(64'hC004_0000_0000_0000, "R1");   // -2.5
        idle(1);
        send(64'h41D8_0000_0000_0000, "R2");   // 1.5 * 2^30
        send(64'h4059_0000_0000_0000, "R2");   // 100.0
        send(64'h41E0_0000_0000_0000, "R3");   // 2^31
        send(64'hC1E0_0000_0020_0000, "R3");   // -2147483649
        send(64'h4415_AF1D_78B5_8C40, "R3");   // 1e20
        send(64'h7FEF_FFFF_FFFF_FFFF, "R3");   // largest finite
        send(64'h4330_0000_0000_0001, "R3");   // 2^52 + 1
        idle(3);
        send(64'hC1E0_0000_0000_0000, "R4");   // -2^31 exact
        send(64'hC1E0_0000_0010_0000, "R4");   // -2147483648.5
        send(64'h7FF8_0000_0000_0000, "R5");   // quiet NaN
        send(64'h7FF0_0000_0000_0001, "R5");   // signalling NaN
        send(64'hFFF8_0000_0000_0000, "R5");   // negative NaN
        send(64'h7FF0_0000_0000_0000, "R6");   // +inf
        send(64'hFFF0_0000_0000_0000, "R6");   // -inf
        idle(2);
        send(64'h0000_0000_0000_0000, "R7");   // +0
        send(64'h8000_0000_0000_0000, "R7");   // -0
        send(64'h0000_0000_0000_0001, "R8");   // smallest subnormal
        send(64'h800F_FFFF_FFFF_FFFF, "R8");   // largest negative subnormal
        send(64'h3FE0_0000_0000_0000, "R9");   // 0.5
        send(64'hBFEF_FFFF_FFFF_FFFF, "R9");   // just above -1
        send(64'h41DF_FFFF_FFC0_0000, "R10");  // 2147483647 exact
        send(64'h41DF_FFFF_FFF0_0000, "R10");  // 2147483647.75
        send(64'h4024_0000_0000_0001, "R10");  // 10 plus one ulp
        idle(4);

        // R11 / R1 sweep: random operands with exponents around the 32-bit edge.
        for (int i = 0; i < 300; i++) begin
            logic [63:0] x;
            rng = next_rand(rng);
            x = {rng[63], 11'd1000 + {5'd0, rng[57:52]}, rng[51:0]};
            send(x, "R11");
            if (rng[5:4] == 2'b00) idle(1);
        end
        idle(5);

        check("R12", {32'd0, q_res.size()}, 64'd0, "all results delivered");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule